// File: doc/BRIEF.md
# Sector flash write controller

This block holds the write-side control of a parallel flash memory that is programmed a whole 256-byte sector at a time. A host drives it like an asynchronous SRAM: active-low chip enable, write enable and output enable, a byte address and a data byte. Each clock in which chip enable and write enable are both low counts as one byte write. Writes to one sector collect in a buffer. When the bus has been quiet for a set number of clocks, a timed program phase copies the buffer into a behavioural storage array.

The upper address bits pick the sector and the low eight bits pick the byte within it. Bytes may arrive in any order. A build can start with software write protection on. In that case plain loads are dropped, and a three-write key opens the part for exactly one sector program. During the program phase the part reports busy, ignores the bus, and answers reads with a status byte whose toggle bit flips on each read.

Top module: `sector_flash_wrctl`

## Requirements
- R1: Address bits [ADDR_W-1:8] select the sector and bits [7:0] select the byte. A program writes only the sector in which its load started, and other sectors keep their contents.
- R2: Bytes of one sector may be written in any address order, and each byte lands at its own address.
- R3: With protection on (LOCK_AT_RESET=1) and no completed key, writes start no load, busy stays 0 and the array is unchanged.
- R4: The key is 0xAA to address 0x155, then 0x55 to 0x2AA, then 0xA0 to 0x155. The key writes are not stored. The first write after the key starts a load, and after that program protection applies again.
- R5: A write that does not match the next key step sends the detector back to its first step.
- R6: With protection off (LOCK_AT_RESET=0), the first write to any address starts a load in that address's sector.
- R7: A load ends after IDLE_LIMIT consecutive clocks without an in-sector write. busy then rises and stays 1 for exactly PROG_CYCLES clocks.
- R8: Bytes of the loaded sector that were not written during the load read back as 0xE5 after the program.
- R9: Writes during the program phase are ignored. During a load, writes to a different sector are ignored and do not restart the idle count.
- R10: A read while busy returns a status byte in which bits 7 and 5..0 are 0. Bit 6 is 0 in the first read cycle and inverts in each later read cycle of the same program phase.
- R11: A read is chip enable and output enable low with write enable high, and it returns the array byte when not busy. When write enable is low, rdata is 0x00 whatever output enable does.
- R12: After reset busy is 0 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low, takes priority over oe_n |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; upper bits select the sector |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Array byte, status byte or 0x00 |
| busy | output | 1 | High during the program phase |

## Verification
On every cycle, the assertions check the shape of the status byte and the way its toggle bit alternates across consecutive reads. They also check that rdata is zero whenever write enable is low, that the program phase is always entered from a load and lasts exactly PROG_CYCLES clocks, that a locked part cannot leave idle without the key, and that the key detector only advances one step or falls back to the start. Only the bench's scenarios can show what the array actually ends up holding. That covers bytes from permuted load orders, the garbage fill of bytes left unwritten, writes ignored while locked, during the program phase or outside the sector, the one-shot effect of the key, and the locked and unlocked builds taking different paths on the same bus traffic.

// File: rtl/sector_flash_wrctl.sv
module sector_flash_wrctl #(
  parameter int          ADDR_W        = 10,
  parameter int          IDLE_LIMIT    = 8,
  parameter int          PROG_CYCLES   = 20,
  parameter bit          LOCK_AT_RESET = 1'b1,
  parameter int          KEY_ADDR_A    = 'h155,
  parameter int          KEY_ADDR_B    = 'h2AA,
  parameter logic [7:0]  GARBAGE       = 8'hE5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int SEC_W     = ADDR_W - 8;
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int IC_W      = $clog2(IDLE_LIMIT + 1);
  localparam int PC_W      = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_LOAD = 2'd1, S_PROG = 2'd2} state_t;

  state_t            st;
  logic [7:0]        mem  [MEM_BYTES];
  logic [7:0]        sbuf [256];
  logic [255:0]      valid;
  logic [SEC_W-1:0]  sec;
  logic [1:0]        kst;
  logic [IC_W-1:0]   icnt;
  logic [PC_W-1:0]   pcnt;
  logic              tgl;
  logic              wr, rd, gate, key_hit, load_wr;

  assign busy    = (st == S_PROG);
  assign wr      = !ce_n && !we_n && !busy;
  assign rd      = !ce_n && !oe_n && we_n;
  assign gate    = !LOCK_AT_RESET || (kst == 2'd3);
  assign load_wr = wr && (((st == S_IDLE) && gate) ||
                          ((st == S_LOAD) && (addr[ADDR_W-1:8] == sec)));
  assign rdata   = !rd ? 8'h00 : busy ? {1'b0, tgl, 6'b0} : mem[addr];

  always_comb begin
    case (kst)
      2'd0:    key_hit = (addr == ADDR_W'(KEY_ADDR_A)) && (wdata == 8'hAA);
      2'd1:    key_hit = (addr == ADDR_W'(KEY_ADDR_B)) && (wdata == 8'h55);
      2'd2:    key_hit = (addr == ADDR_W'(KEY_ADDR_A)) && (wdata == 8'hA0);
      default: key_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk)
    if (load_wr) sbuf[addr[7:0]] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      kst   <= 2'd0;
      sec   <= '0;
      icnt  <= '0;
      pcnt  <= '0;
      tgl   <= 1'b0;
      valid <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      if (!busy)   tgl <= 1'b0;
      else if (rd) tgl <= ~tgl;
      case (st)
        S_IDLE: if (wr) begin
          if (gate) begin
            st    <= S_LOAD;
            sec   <= addr[ADDR_W-1:8];
            valid <= 256'b1 << addr[7:0];
            icnt  <= '0;
            kst   <= 2'd0;
          end else begin
            kst <= key_hit ? kst + 2'd1 : 2'd0;
          end
        end
        S_LOAD: if (load_wr) begin
          valid[addr[7:0]] <= 1'b1;
          icnt             <= '0;
        end else if (icnt == IC_W'(IDLE_LIMIT - 1)) begin
          st   <= S_PROG;
          pcnt <= '0;
        end else begin
          icnt <= icnt + IC_W'(1);
        end
        S_PROG: if (pcnt == PC_W'(PROG_CYCLES - 1)) begin
          st <= S_IDLE;
          for (int i = 0; i < 256; i++)
            mem[{sec, 8'(i)}] <= valid[i] ? sbuf[i] : GARBAGE;
        end else begin
          pcnt <= pcnt + PC_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_flash_wrctl_chk.sv
module sector_flash_wrctl_chk #(
  parameter int PROG_CYCLES   = 20,
  parameter bit LOCK_AT_RESET = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic [7:0] rdata,
  input logic       busy,
  input logic [1:0] st,
  input logic [1:0] kst
);
  localparam int BL_W = $clog2(PROG_CYCLES + 2);
  logic [BL_W-1:0] blen;
  logic rd_c, wr_c;
  assign rd_c = !ce_n && !oe_n && we_n;
  assign wr_c = !ce_n && !we_n;

  always_ff @(posedge clk)
    if (!rst_n)    blen <= '0;
    else if (busy) blen <= blen + BL_W'(1);
    else           blen <= '0;

  p_prog_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> blen < BL_W'(PROG_CYCLES));
  p_prog_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(blen) == BL_W'(PROG_CYCLES - 1));
  p_prog_from_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st) == 2'd1);
  p_status_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_c |-> rdata[7] == 1'b0 && rdata[5:0] == 6'd0);
  p_status_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_c && $past(busy && rd_c) |-> rdata[6] != $past(rdata[6]));
  p_we_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |-> rdata == 8'h00);
  p_locked_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    LOCK_AT_RESET && st == 2'd0 && kst != 2'd3 && wr_c |=> st == 2'd0);
  p_key_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd0 && kst != 2'd3 && wr_c |=> kst == 2'd0 || kst == $past(kst) + 2'd1);
endmodule

bind sector_flash_wrctl sector_flash_wrctl_chk #(
  .PROG_CYCLES(PROG_CYCLES), .LOCK_AT_RESET(LOCK_AT_RESET)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .rdata(rdata), .busy(busy), .st(st), .kst(kst)
);

// File: tb/sector_flash_wrctl_tb_top.sv
module sector_flash_wrctl_tb_top;
  localparam int AW = 10;
  localparam int IL = 8;
  localparam int PC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata0, rdata1;
  logic busy0, busy1;

  always #4 clk = ~clk;

  sector_flash_wrctl #(.ADDR_W(AW), .IDLE_LIMIT(IL), .PROG_CYCLES(PC), .LOCK_AT_RESET(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata0), .busy(busy0));
  sector_flash_wrctl #(.ADDR_W(AW), .IDLE_LIMIT(IL), .PROG_CYCLES(PC), .LOCK_AT_RESET(1'b0)) dut_open_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata1), .busy(busy1));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R12";
  bit done = 1'b0;

  // behavioural reference, one copy per instance (0 locked, 1 open)
  bit       m_lock [2] = '{1'b1, 1'b0};
  int       m_st [2], m_key [2], m_sec [2], m_ic [2], m_pc [2];
  bit       m_tgl [2];
  bit       m_val [2][256];
  logic [7:0] m_buf [2][256];
  logic [7:0] m_mem [2][1024];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_st[i] = 0; m_key[i] = 0; m_sec[i] = 0; m_ic[i] = 0; m_pc[i] = 0; m_tgl[i] = 0;
        for (int j = 0; j < 1024; j++) m_mem[i][j] = 8'hFF;
      end else begin
        bit w, r, ok;
        int a;
        a = int'(addr);
        w = !ce_n && !we_n && m_st[i] != 2;
        r = !ce_n && !oe_n && we_n;
        if (m_st[i] != 2) m_tgl[i] = 0;
        else if (r) m_tgl[i] = !m_tgl[i];
        if (m_st[i] == 0) begin
          if (w) begin
            if (!m_lock[i] || m_key[i] == 3) begin
              m_st[i] = 1; m_sec[i] = a / 256; m_ic[i] = 0; m_key[i] = 0;
              for (int j = 0; j < 256; j++) m_val[i][j] = 0;
              m_buf[i][a % 256] = wdata; m_val[i][a % 256] = 1;
            end else begin
              case (m_key[i])
                0: ok = (a == 'h155) && (wdata == 8'hAA);
                1: ok = (a == 'h2AA) && (wdata == 8'h55);
                default: ok = (a == 'h155) && (wdata == 8'hA0);
              endcase
              m_key[i] = ok ? m_key[i] + 1 : 0;
            end
          end
        end else if (m_st[i] == 1) begin
          if (w && a / 256 == m_sec[i]) begin
            m_buf[i][a % 256] = wdata; m_val[i][a % 256] = 1; m_ic[i] = 0;
          end else if (m_ic[i] == IL - 1) begin
            m_st[i] = 2; m_pc[i] = 0;
          end else m_ic[i]++;
        end else begin
          if (m_pc[i] == PC - 1) begin
            m_st[i] = 0;
            for (int j = 0; j < 256; j++)
              m_mem[i][m_sec[i] * 256 + j] = m_val[i][j] ? m_buf[i][j] : 8'hE5;
          end else m_pc[i]++;
        end
      end
    end
  end

  task automatic compare();
    for (int i = 0; i < 2; i++) begin
      logic [7:0] er, ar;
      logic eb, ab;
      eb = (m_st[i] == 2);
      if (!(!ce_n && !oe_n && we_n)) er = 8'h00;
      else if (eb) er = {1'b0, m_tgl[i], 6'b0};
      else er = m_mem[i][addr];
      ab = (i == 0) ? busy0 : busy1;
      ar = (i == 0) ? rdata0 : rdata1;
      n_cmp += 2;
      if (ab !== eb) begin
        n_bad++;
        $display("FAIL %s inst%0d busy actual=%0b expected=%0b t=%0t", cur_req, i, ab, eb, $time);
      end
      if (ar !== er) begin
        n_bad++;
        $display("FAIL %s inst%0d rdata actual=%02h expected=%02h addr=%03h t=%0t", cur_req, i, ar, er, addr, $time);
      end
    end
  endtask

  task automatic step(input logic c, input logic w, input logic o, input int a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = AW'(a); wdata = d;
    #2;
    if (rst_n) compare();
  endtask

  task automatic wr(input int a, input logic [7:0] d); step(1'b0, 1'b0, 1'b1, a, d); endtask
  task automatic rd(input int a); step(1'b0, 1'b1, 1'b0, a, 8'h00); endtask
  task automatic idle(input int n); for (int k = 0; k < n; k++) step(1'b1, 1'b1, 1'b1, 0, 8'h00); endtask
  task automatic settle(); idle(IL + PC + 4); endtask
  task automatic key(); wr('h155, 8'hAA); wr('h2AA, 8'h55); wr('h155, 8'hA0); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired under %s", cur_req);
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R12: reset state
    cur_req = "R12";
    rd(0); rd('h155); rd('h3FF); idle(2);
    // R3 locked ignore; R6 open part loads; R8 garbage fill in open part
    cur_req = "R3/R6/R8";
    for (int k = 0; k < 16; k++) wr('h010 + k, 8'(k * 7 + 1));
    settle();
    for (int k = 0; k < 20; k++) rd('h008 + k);
    rd('h0FF);
    // R5: broken key, then a plain write must still be dropped by locked part
    cur_req = "R5";
    wr('h155, 8'hAA); wr('h2AA, 8'h11); wr('h155, 8'hA0); wr('h100, 8'h77);
    settle();
    rd('h100); rd('h155); rd('h2AA);
    // R4/R2/R1/R7: key then full sector 3 in permuted order
    cur_req = "R4/R2/R1/R7";
    key();
    for (int k = 0; k < 256; k++) wr('h300 + ((k * 37) % 256), 8'(((k * 37) % 256) ^ 8'h3C));
    idle(IL);
    // R10 status reads, R9 writes while busy ignored
    cur_req = "R10/R9";
    rd('h300); rd('h301); rd('h302); idle(1); rd('h303); rd('h304);
    wr('h355, 8'h00); wr('h100, 8'h42);
    settle();
    cur_req = "R1/R2";
    for (int k = 0; k < 256; k += 17) rd('h300 + k);
    rd('h3FF); rd('h2FF); rd('h200);
    // R4: protection is back after the keyed program
    cur_req = "R4";
    wr('h300, 8'h99);
    settle();
    rd('h300);
    // R9: foreign-sector write during a load (open part)
    cur_req = "R9";
    wr('h080, 8'h12); wr('h280, 8'h34); wr('h081, 8'h56);
    settle();
    rd('h080); rd('h081); rd('h280); rd('h082);
    // R11: write enable overrides output enable
    cur_req = "R11";
    step(1'b0, 1'b0, 1'b0, 'h3FE, 8'h42);
    step(1'b1, 1'b0, 1'b0, 'h3FE, 8'h00);
    rd('h3FE);
    settle();
    rd('h3FE); rd('h3FD);
    finish_run();
  end
endmodule